// File: doc/BRIEF.md
# Up-Counting Compare PWM Generator

This block drives one pulse-width-modulated pin from a counter that climbs from zero to a programmable top value and then starts again at zero. One PWM cycle therefore lasts top+1 clocks. The top value alone sets the resolution: a top of 255 gives 256 duty steps, and any top from 1 to 2^CNT_W-1 is legal. A threshold value sets how many clocks of each cycle the pin is high. A second output mode ignores the counter and holds the pin at a programmed level. This gives a true 0 % or 100 % with no pulse at all.

The top, threshold and mode inputs are sampled into a shadow stage every clock. They become active only at the first clock of a new cycle, so a cycle always runs with one consistent set of values. The pin level bit is taken from the shadow stage directly. Two one-clock event outputs mark the first clock of every cycle and the clock at which the pin falls. A controller uses them to pace duty ramps. While the enable input is low, the counter is parked at zero, no events are produced, and the pin follows the level bit.

Top module: `pwmgen_top`

## Requirements
- R1: While enabled with a top value P (P >= 1), `cyc_start_o` is high on the first clock of every cycle, and consecutive pulses are exactly P+1 clocks apart.
- R2: In compare mode (`mode_i` = 0) with threshold C, `pwm_o` is high on the first min(C, P) clocks of each cycle and low on the rest.
- R3: With threshold 0 in compare mode, the set and clear points coincide and clearing wins, so `pwm_o` stays low for the whole cycle.
- R4: With a threshold at or above P in compare mode, `pwm_o` is high for exactly P clocks and low for the last clock of the cycle, so a full-on level is never reached through the threshold.
- R5: In static mode (`mode_i` = 1), `pwm_o` equals the level bit at all times. Cycle and fall events keep running.
- R6: With `en_i` low, no events are produced and `pwm_o` follows the level bit. After `en_i` rises, the first cycle-start pulse appears on the second clock, sampled after the rising edge.
- R7: A change of top, threshold or mode takes effect only at the next cycle start. The cycle in progress completes with the values it began with.
- R8: `fall_o` is high for one clock, at offset C of the cycle, when C <= P. It never fires when C > P.
- R9: After reset, `pwm_o`, `cyc_start_o` and `fall_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks the counter at zero |
| top_i | input | CNT_W | Top count value P; cycle is P+1 clocks |
| thresh_i | input | CNT_W | Threshold C; number of high clocks per cycle in compare mode |
| mode_i | input | 1 | 0 = compare PWM, 1 = static level |
| level_i | input | 1 | Pin level in static mode and while disabled |
| pwm_o | output | 1 | Registered PWM pin |
| cyc_start_o | output | 1 | One-clock pulse on the first clock of each cycle |
| fall_o | output | 1 | One-clock pulse at the threshold offset |

## Verification
The bench sweeps every threshold from 0 to P+2 for a range of small top values and a larger one, and checks each clock of two full cycles. A design that let the set point win at threshold 0 would emit a one-clock spike. One that stopped clearing at or above the top would reach a constant high, and one that compared with the wrong relation would be off by one clock of duty. Values are changed in the middle of a running cycle. A design without the shadow stage would cut that cycle short, or change its duty halfway, and the bench would see a wrong cycle length or a wrong pulse width. Enable is toggled and the delay to the first cycle-start pulse is measured, which catches a counter that is not parked at zero or events that keep running while idle.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  typedef enum logic {
    MODE_CMP    = 1'b0,
    MODE_STATIC = 1'b1
  } out_mode_e;
endpackage

// File: rtl/pwmgen_counter.sv
module pwmgen_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_top;

  assign at_top = (cnt_q == top_i);
  // New settings are taken while parked, on the first running clock, and at the top.
  assign load_o = !en_i || !run_q || at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= en_i;
      if (load_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R1: the count never passes the active top value.
  p_count_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= top_i));

  // R1: reaching the top while enabled returns to zero.
  p_top_wraps_r1: assert property (@(posedge clk) disable iff (rst)
    (run_q && en_i && at_top) |=> (cnt_q == '0));
endmodule

// File: rtl/pwmgen_shadow.sv
module pwmgen_shadow
  import pwmgen_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  out_mode_e        mode_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] act_top_o,
  output logic [CNT_W-1:0] act_thresh_o,
  output out_mode_e        act_mode_o,
  output logic             level_o
);
  logic [CNT_W-1:0] sh_top, sh_thresh;
  out_mode_e        sh_mode;
  logic             sh_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_top    <= '0;
      sh_thresh <= '0;
      sh_mode   <= MODE_CMP;
      sh_level  <= 1'b0;
    end else begin
      sh_top    <= top_i;
      sh_thresh <= thresh_i;
      sh_mode   <= mode_i;
      sh_level  <= level_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_top_o    <= '0;
      act_thresh_o <= '0;
      act_mode_o   <= MODE_CMP;
    end else if (load_i) begin
      act_top_o    <= sh_top;
      act_thresh_o <= sh_thresh;
      act_mode_o   <= sh_mode;
    end
  end

  assign level_o = sh_level;

  // R7: active settings only move on a load from the counter.
  p_active_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(act_top_o) && $stable(act_thresh_o) && $stable(act_mode_o)));
endmodule

// File: rtl/pwmgen_outstage.sv
module pwmgen_outstage
  import pwmgen_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  out_mode_e        mode_i,
  input  logic             level_i,
  output logic             pwm_o,
  output logic             cyc_start_o,
  output logic             fall_o
);
  logic cmp_level;
  logic hit;

  // High below the threshold; the top clock is always low in compare mode.
  always_comb begin
    cmp_level = (cnt_i < thresh_i) && (cnt_i < top_i);
    hit       = run_i && (cnt_i == thresh_i) && (thresh_i <= top_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o       <= 1'b0;
      cyc_start_o <= 1'b0;
      fall_o      <= 1'b0;
    end else begin
      cyc_start_o <= run_i && (cnt_i == '0);
      fall_o      <= hit;
      if (!run_i || mode_i == MODE_STATIC) pwm_o <= level_i;
      else                                 pwm_o <= cmp_level;
    end
  end

  // R5: static mode copies the level bit.
  p_static_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == MODE_STATIC) |=> (pwm_o == $past(level_i)));

  // R3: zero threshold never raises the pin.
  p_zero_thresh_low_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == MODE_CMP && thresh_i == '0) |=> !pwm_o);

  // R4: the top clock of a compare cycle is low.
  p_top_clock_low_r4: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == MODE_CMP && cnt_i == top_i) |=> !pwm_o);

  // R6: no events while parked.
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!cyc_start_o && !fall_o));
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
  import pwmgen_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             mode_i,
  input  logic             level_i,
  output logic             pwm_o,
  output logic             cyc_start_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             load;
  logic [CNT_W-1:0] act_top, act_thresh;
  out_mode_e        act_mode;
  logic             sh_level;

  pwmgen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .top_i  (act_top),
    .cnt_o  (cnt),
    .run_o  (run),
    .load_o (load)
  );

  pwmgen_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .top_i        (top_i),
    .thresh_i     (thresh_i),
    .mode_i       (out_mode_e'(mode_i)),
    .level_i      (level_i),
    .act_top_o    (act_top),
    .act_thresh_o (act_thresh),
    .act_mode_o   (act_mode),
    .level_o      (sh_level)
  );

  pwmgen_outstage #(.CNT_W(CNT_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .cnt_i       (cnt),
    .top_i       (act_top),
    .thresh_i    (act_thresh),
    .mode_i      (act_mode),
    .level_i     (sh_level),
    .pwm_o       (pwm_o),
    .cyc_start_o (cyc_start_o),
    .fall_o      (fall_o)
  );
endmodule

// File: tb/pwmgen_top_test.sv
module pwmgen_top_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, en, mode, level;
  logic [W-1:0] top, thresh;
  logic         pwm, cs, fall;

  int checks = 0;
  int fails  = 0;

  pwmgen_top #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .en_i(en), .top_i(top), .thresh_i(thresh),
    .mode_i(mode), .level_i(level), .pwm_o(pwm), .cyc_start_o(cs), .fall_o(fall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_start(output int n);
    n = -1;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (cs) begin n = i; break; end
    end
    chk(n > 0, "R1 cycle start seen", n, 1);
  endtask

  // Called at the negedge showing offset 0; returns at offset 0 of the next cycle.
  task automatic check_cycle(input int p, input int c, input bit stat, input bit lv);
    int hi;
    string tg;
    hi = (c < p) ? c : p;
    tg = stat ? "R5" : (c == 0) ? "R3" : (c >= p) ? "R4" : "R2";
    for (int off = 0; off <= p; off++) begin
      int ep;
      if (off > 0) @(negedge clk);
      ep = stat ? int'(lv) : int'(off < hi);
      chk(pwm == ep, tg, pwm, ep);
      chk(cs == (off == 0), "R1", cs, int'(off == 0));
      chk(fall == (c <= p && off == c), "R8", fall, int'(c <= p && off == c));
    end
    @(negedge clk);
    chk(cs == 1'b1, "R1 spacing", cs, 1);
  endtask

  task automatic setup(input int p, input int c, input bit md, input bit lv);
    int n;
    @(negedge clk);
    en = 1'b0; top = W'(p); thresh = W'(c); mode = md; level = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b1, "R6 idle level high", pwm, 1);
    chk(!cs && !fall, "R6 idle events", int'(cs | fall), 0);
    level = lv;
    repeat (3) @(negedge clk);
    chk(pwm == lv, "R6 idle level", pwm, lv);
    en = 1'b1;
    wait_start(n);
    chk(n == 2, "R6 first start delay", n, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int plist[7] = '{1, 2, 3, 4, 5, 6, 40};
    rst = 1'b1; en = 1'b0; mode = 1'b0; level = 1'b0; top = '0; thresh = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm == 0, "R9 pwm", pwm, 0);
    chk(cs == 0, "R9 start", cs, 0);
    chk(fall == 0, "R9 fall", fall, 0);

    // Sweep thresholds across each top value.
    foreach (plist[k]) begin
      for (int c = 0; c <= plist[k] + 2; c++) begin
        if (plist[k] == 40 && !(c < 3 || c > 37 || c == 20)) continue;
        setup(plist[k], c, 1'b0, 1'b0);
        check_cycle(plist[k], c, 1'b0, 1'b0);
        check_cycle(plist[k], c, 1'b0, 1'b0);
      end
    end

    // R5: static mode, both levels.
    setup(5, 2, 1'b1, 1'b1);
    check_cycle(5, 2, 1'b1, 1'b1);
    setup(5, 2, 1'b1, 1'b0);
    check_cycle(5, 2, 1'b1, 1'b0);

    // R7: mid-cycle changes apply at the next cycle start.
    setup(7, 2, 1'b0, 1'b0);
    top = W'(4); thresh = W'(6);
    check_cycle(7, 2, 1'b0, 1'b0);
    mode = 1'b1; level = 1'b1;
    check_cycle(4, 6, 1'b0, 1'b0);
    check_cycle(4, 6, 1'b1, 1'b1);
    mode = 1'b0; thresh = W'(1);
    check_cycle(4, 6, 1'b1, 1'b1);
    check_cycle(4, 1, 1'b0, 1'b0);

    // R6: disable mid-run, events stop and level is followed.
    en = 1'b0; level = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      chk(!cs && !fall, "R6 quiet after disable", int'(cs | fall), 0);
      chk(pwm == 1'b1, "R6 level after disable", pwm, 1);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule